// File: doc/BRIEF.md
# Frame-Aligned Two-Lane ADC Deserializer

This block turns the serial output of a high-speed data converter back into parallel samples. The converter sends two data lanes and a frame lane, all timed by a source-synchronous bit clock. Every lane, the frame lane included, is registered on both edges of that clock. The frame lane is never used as a clock. It is an ordinary bit stream, and each low-to-high step in it marks the start of a new 16-bit word. Each word spends eight bit-slots on each data lane. The block drops the two zero-padding bits at the top of each word and presents the remaining 14 bits together with a one-cycle valid strobe.

Board wiring differs from one source board to the next. Two static configuration inputs cover this. One inverts any lane, the frame lane included, to correct a swapped differential pair. The other exchanges which data lane carries the upper byte. A lock tracker compares the frame bits of every completed word against the expected pattern, and samples are released only while the tracker is locked. The output is a plain valid strobe with no ready input. The converter cannot be paused, so the block has no back-pressure and the receiver must take a sample in the cycle its strobe is high.

Top module: `adc_frame_deser`

## Requirements
- R1: Each lane is registered on both edges of `clk`. Within one clock period the bit registered on the rising edge comes before the bit registered on the falling edge. Each data lane carries 8 bits of a word with the most significant bit first. By default lane 0 carries word bits 15..8 and lane 1 carries bits 7..0.
- R2: The frame lane uses the same both-edge capture path as the data lanes. A word ends at the bit just before a 0-to-1 step in the captured frame stream. That step may fall on a rising-edge bit or on a falling-edge bit.
- R3: `sample_o` carries bits 13..0 of each delivered word. `sample_valid_o` is high for exactly one cycle per delivered word, and every word is delivered at most once, in arrival order.
- R4: Setting bit i of `lane_inv_i` inverts data lane i before capture, and `frame_inv_i` inverts the frame lane. Once the matching inversion is applied, an inverted source gives the same samples as an uninverted one.
- R5: When `lane_swap_i` is 1, lane 1 carries bits 15..8 and lane 0 carries bits 7..0.
- R6: A word's frame bits match when, oldest first, they read 11110000. While unlocked, `frame_locked_o` rises on the 4th consecutive matching word, and that word is the first one delivered.
- R7: While locked, a single mismatching word is still delivered and lock holds. The 2nd consecutive mismatch drops `frame_locked_o`, and that word is not delivered.
- R8: No sample is delivered while the tracker is unlocked, including before lock is first reached.
- R9: `pad_err_o` is high in the same cycle as `sample_valid_o` when either of word bits 15 or 14 is 1. It is never high without `sample_valid_o`.
- R10: A synchronous active-high `rst` clears the capture and shift registers, the lock state, and all outputs. One cycle after reset, `sample_valid_o` and `frame_locked_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source-synchronous bit clock; both edges capture data |
| rst | input | 1 | Synchronous active-high reset |
| data_lane_i | input | 2 | Serial data lanes |
| frame_lane_i | input | 1 | Serial frame lane, handled as data |
| lane_inv_i | input | 2 | Per data lane polarity inversion |
| frame_inv_i | input | 1 | Frame lane polarity inversion |
| lane_swap_i | input | 1 | Exchanges the byte carried by each data lane |
| sample_o | output | 14 | Reassembled sample with the padding removed |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |
| frame_locked_o | output | 1 | Frame pattern lock status |
| pad_err_o | output | 1 | Nonzero padding in the delivered word |

## Verification
The lock tracker and the padding check both act on a single word, so they can fall in the same cycle. The word that first brings lock carries a nonzero bit 14. The first mismatch after lock is made on a word whose bit 15 is set. A second test puts both corrupted words at the end of a run, so the run finishes unlocked. In every case the bench builds the frame and data bits itself and keeps its own good/bad counters. From these it predicts which words are delivered and what `pad_err_o` shows on each. It checks every strobe against that prediction and checks the final lock level, over all inversion masks, both lane orders and both edge phases of the frame step.

// File: rtl/adc_deser_pkg.sv
`timescale 1ns/1ps
package adc_deser_pkg;
  typedef enum logic {
    LK_HUNT   = 1'b0,
    LK_LOCKED = 1'b1
  } lock_state_e;
endpackage

// File: rtl/adc_ddr_capture.sv
`timescale 1ns/1ps
// Both-edge capture of every lane, with polarity correction applied at the pin.
module adc_ddr_capture #(
  parameter int unsigned CH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] din,
  input  logic [CH-1:0] inv,
  output logic [CH-1:0] rise_q,
  output logic [CH-1:0] fall_q
);
  logic [CH-1:0] pin_fix;
  assign pin_fix = din ^ inv;

  always_ff @(posedge clk) begin
    if (rst) rise_q <= '0;
    else     rise_q <= pin_fix;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= pin_fix;
  end
endmodule

// File: rtl/adc_word_aligner.sv
`timescale 1ns/1ps
// Shifts two bits per lane per clock and finds word ends from the frame lane (top channel).
module adc_word_aligner #(
  parameter int unsigned CH    = 3,
  parameter int unsigned SLOTS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CH-1:0]             rise_q,
  input  logic [CH-1:0]             fall_q,
  output logic                      boundary,
  output logic [CH-1:0][SLOTS-1:0]  words
);
  localparam int unsigned SR_W = SLOTS + 2;
  localparam int unsigned FL   = CH - 1;

  logic [CH-1:0][2:0] tail;
  logic               step_rise;
  logic               step_fall;

  // A 0-to-1 step whose 1 is the falling-edge bit (tail[0]).
  assign step_fall = ~tail[FL][1] & tail[FL][0];
  // A 0-to-1 step whose 1 is the rising-edge bit (tail[1]).
  assign step_rise = ~tail[FL][2] & tail[FL][1];
  assign boundary  = step_rise | step_fall;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [SR_W-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= {sr[SR_W-3:0], rise_q[c], fall_q[c]};
    end
    assign tail[c]  = sr[2:0];
    assign words[c] = step_fall ? sr[SLOTS:1] : sr[SLOTS+1:2];
  end
endmodule

// File: rtl/adc_lock_tracker.sv
`timescale 1ns/1ps
module adc_lock_tracker
  import adc_deser_pkg::*;
#(
  parameter int unsigned GOOD_N = 4,
  parameter int unsigned BAD_N  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  input  logic match,
  output logic locked,
  output logic lock_next
);
  localparam int unsigned GW = $clog2(GOOD_N + 1);
  localparam int unsigned BW = $clog2(BAD_N + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_N - 1);
  localparam logic [BW-1:0] BAD_LAST  = BW'(BAD_N - 1);

  lock_state_e     st_q, st_d;
  logic [GW-1:0]   good_q, good_d;
  logic [BW-1:0]   bad_q, bad_d;

  always_comb begin
    st_d   = st_q;
    good_d = good_q;
    bad_d  = bad_q;
    if (boundary) begin
      if (match) begin
        bad_d = '0;
        if (st_q == LK_HUNT) begin
          if (good_q == GOOD_LAST) begin
            st_d   = LK_LOCKED;
            good_d = '0;
          end else begin
            good_d = good_q + GW'(1);
          end
        end
      end else begin
        good_d = '0;
        if (st_q == LK_LOCKED) begin
          if (bad_q == BAD_LAST) begin
            st_d  = LK_HUNT;
            bad_d = '0;
          end else begin
            bad_d = bad_q + BW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LK_HUNT;
      good_q <= '0;
      bad_q  <= '0;
    end else begin
      st_q   <= st_d;
      good_q <= good_d;
      bad_q  <= bad_d;
    end
  end

  assign locked    = (st_q == LK_LOCKED);
  assign lock_next = (st_d == LK_LOCKED);
endmodule

// File: rtl/adc_frame_deser.sv
`timescale 1ns/1ps
module adc_frame_deser #(
  parameter int unsigned NUM_LANES = 2,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned PAD_W     = 2,
  parameter int unsigned LOCK_GOOD = 4,
  parameter int unsigned LOCK_BAD  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LANES-1:0]        data_lane_i,
  input  logic                        frame_lane_i,
  input  logic [NUM_LANES-1:0]        lane_inv_i,
  input  logic                        frame_inv_i,
  input  logic                        lane_swap_i,
  output logic [WORD_W-PAD_W-1:0]     sample_o,
  output logic                        sample_valid_o,
  output logic                        frame_locked_o,
  output logic                        pad_err_o
);
  localparam int unsigned SLOTS    = WORD_W / NUM_LANES;
  localparam int unsigned CH       = NUM_LANES + 1;
  localparam int unsigned SAMPLE_W = WORD_W - PAD_W;
  localparam logic [SLOTS-1:0] FRAME_PAT = ~SLOTS'((1 << (SLOTS / 2)) - 1);

  logic [CH-1:0]            rise_q, fall_q;
  logic                     boundary;
  logic [CH-1:0][SLOTS-1:0] words;
  logic [WORD_W-1:0]        word;
  logic                     lock_next;
  logic                     deliver;

  adc_ddr_capture #(.CH(CH)) cap_i (
    .clk    (clk),
    .rst    (rst),
    .din    ({frame_lane_i, data_lane_i}),
    .inv    ({frame_inv_i, lane_inv_i}),
    .rise_q (rise_q),
    .fall_q (fall_q)
  );

  adc_word_aligner #(.CH(CH), .SLOTS(SLOTS)) aln_i (
    .clk      (clk),
    .rst      (rst),
    .rise_q   (rise_q),
    .fall_q   (fall_q),
    .boundary (boundary),
    .words    (words)
  );

  adc_lock_tracker #(.GOOD_N(LOCK_GOOD), .BAD_N(LOCK_BAD)) lck_i (
    .clk       (clk),
    .rst       (rst),
    .boundary  (boundary),
    .match     (words[CH-1] == FRAME_PAT),
    .locked    (frame_locked_o),
    .lock_next (lock_next)
  );

  // Default: lane 0 holds the most significant slice; swap reverses lane order.
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_asm
    assign word[WORD_W-1-i*SLOTS -: SLOTS] =
      lane_swap_i ? words[NUM_LANES-1-i] : words[i];
  end

  assign deliver = boundary & lock_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
      pad_err_o      <= 1'b0;
    end else begin
      sample_valid_o <= deliver;
      pad_err_o      <= deliver & (|word[WORD_W-1:SAMPLE_W]);
      if (deliver) sample_o <= word[SAMPLE_W-1:0];
    end
  end
endmodule

// File: rtl/adc_frame_deser_chk.sv
`timescale 1ns/1ps
module adc_frame_deser_chk (
  input logic clk,
  input logic rst,
  input logic sample_valid_o,
  input logic frame_locked_o,
  input logic pad_err_o
);
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |-> frame_locked_o); // R8
  AST_LOCK_RISE_DELIVERS: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_locked_o) |-> sample_valid_o); // R6
  AST_LOCK_FALL_SILENT: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_locked_o) |-> !sample_valid_o); // R7
  AST_PAD_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    pad_err_o |-> sample_valid_o); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sample_valid_o && !frame_locked_o && !pad_err_o)); // R10
endmodule

bind adc_frame_deser adc_frame_deser_chk chk_i (
  .clk            (clk),
  .rst            (rst),
  .sample_valid_o (sample_valid_o),
  .frame_locked_o (frame_locked_o),
  .pad_err_o      (pad_err_o)
);

// File: tb/adc_frame_deser_tb_top.sv
`timescale 1ns/1ps
module adc_frame_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  data_lane = '0;
  logic        frame_lane = 1'b0;
  logic [1:0]  lane_inv = '0;
  logic        frame_inv = 1'b0;
  logic        lane_swap = 1'b0;
  logic [13:0] sample;
  logic        sample_valid, frame_locked, pad_err;

  always #2.5 clk = ~clk;

  adc_frame_deser dut_i (
    .clk            (clk),
    .rst            (rst),
    .data_lane_i    (data_lane),
    .frame_lane_i   (frame_lane),
    .lane_inv_i     (lane_inv),
    .frame_inv_i    (frame_inv),
    .lane_swap_i    (lane_swap),
    .sample_o       (sample),
    .sample_valid_o (sample_valid),
    .frame_locked_o (frame_locked),
    .pad_err_o      (pad_err)
  );

  int checks = 0;
  int errors = 0;
  logic sb0 [0:255];
  logic sb1 [0:255];
  logic sbf [0:255];
  int slen;
  logic [13:0] e_smp [0:63];
  logic        e_pad [0:63];
  int e_wr, e_rd;
  string tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: every strobe must match the next predicted word.
  always @(negedge clk) begin
    if (!rst) begin
      if (sample_valid) begin
        if (e_rd >= e_wr) begin
          chk(1'b0, "R8", "unexpected sample_valid", 1, 0);
        end else begin
          chk(sample == e_smp[e_rd], tag, "sample value", int'(sample), int'(e_smp[e_rd]));
          chk(pad_err == e_pad[e_rd], "R9", "pad_err with sample", int'(pad_err), int'(e_pad[e_rd]));
          e_rd++;
        end
      end else if (pad_err) begin
        chk(1'b0, "R9", "pad_err without valid", 1, 0);
      end
    end
  end

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) begin
      sb0[slen] = 1'b0; sb1[slen] = 1'b0; sbf[slen] = 1'b0; slen++;
    end
  endtask

  // R1 ordering: lane 0 = bits 15..8 MSB first; R5 swap exchanges lanes.
  task automatic push_word(input logic [15:0] w, input logic [7:0] fr, input bit sw);
    logic [7:0] l0, l1;
    l0 = sw ? w[7:0] : w[15:8];
    l1 = sw ? w[15:8] : w[7:0];
    for (int b = 7; b >= 0; b--) begin
      sb0[slen] = l0[b]; sb1[slen] = l1[b]; sbf[slen] = fr[b]; slen++;
    end
  endtask

  // Rising-edge bit is driven first, falling-edge bit second (R1, R2).
  task automatic play();
    for (int i = 0; i < slen; i += 2) begin
      @(negedge clk); #1;
      data_lane  = {sb1[i], sb0[i]} ^ lane_inv;
      frame_lane = sbf[i] ^ frame_inv;
      @(posedge clk); #1;
      data_lane  = {sb1[i+1], sb0[i+1]} ^ lane_inv;
      frame_lane = sbf[i+1] ^ frame_inv;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    data_lane = lane_inv;
    frame_lane = frame_inv;
    repeat (3) @(posedge clk);
    #1;
    // R10: outputs and lock cleared while reset held.
    chk(!sample_valid && !frame_locked && !pad_err, "R10", "reset state",
        int'({sample_valid, frame_locked, pad_err}), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_case(input int r);
    int mode, good, bad;
    bit lk, bad_word;
    logic [15:0] w;
    lane_swap = r[0];          // R5
    lane_inv  = r[2:1];        // R4
    frame_inv = r[3];          // R4
    mode = (r + (r >> 2)) % 4; // R6 R7 corruption patterns
    if (lane_swap) tag = "R5";
    else if (r[3:1] != 0) tag = "R4";
    else if (r[4]) tag = "R2";
    else tag = "R3";
    e_wr = 0; e_rd = 0; slen = 0;
    good = 0; bad = 0; lk = 1'b0;
    do_reset();
    push_idle(4 + int'(r[4])); // R2: odd offset puts the frame step on a falling-edge bit
    for (int k = 0; k < 12; k++) begin
      w = 16'((r * 4099 + k * 26021) ^ (k << 9));
      w[15] = (k % 3 == 2);
      w[14] = (k == 3) || (k == 9);
      bad_word = (mode == 1 && k == 5) || (mode == 2 && (k == 5 || k == 6)) ||
                 (mode == 3 && (k == 10 || k == 11));
      push_word(w, bad_word ? 8'hE0 : 8'hF0, lane_swap);
      if (!bad_word) begin
        bad = 0;
        if (!lk) begin
          if (good == 3) begin lk = 1'b1; good = 0; end
          else good++;
        end
      end else begin
        good = 0;
        if (lk) begin
          if (bad == 1) begin lk = 1'b0; bad = 0; end
          else bad++;
        end
      end
      if (lk) begin
        e_smp[e_wr] = w[13:0];
        e_pad[e_wr] = |w[15:14];
        e_wr++;
      end
    end
    push_word(16'h0000, 8'hF0, lane_swap); // closes the last real word
    push_idle(6 + (slen % 2));
    play();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(e_rd == e_wr, "R6", "delivered word count", e_rd, e_wr);
    chk(frame_locked == lk, (mode == 3) ? "R7" : "R6", "final lock", int'(frame_locked), int'(lk));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R3";
    e_wr = 0; e_rd = 0;
    for (int r = 0; r < 32; r++) run_case(r);
    do_reset(); // R10 after a locked run
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule